// File: doc/BRIEF.md
# Programmable CPU Clock Control Unit

This block holds the clock control register of a small microcontroller and the logic that register steers. It decodes one address on a simple register bus. It accepts writes and returns the register contents on reads. From the oscillator clock it derives a one-cycle CPU clock enable. The enable pulses at one of four rates: every oscillator cycle, every 2nd, every 8th or every 16th.

A Stop request freezes the prescaler and raises an oscillator-stop output. A wake-up enable field decides whether an external interrupt may end the Stop state. The field is active-low. Once Stop is entered, only reset or a permitted interrupt ends it.

Reset selects the slowest rate and permits interrupt wake-up. Software speeds the CPU up afterwards by writing a faster rate code. A rate change never takes effect in the middle of a prescaler period. It is applied when the 4-bit counter wraps. Every enable gap is therefore one of the legal spacings.

Top module: `clkctl_top`

## Requirements
- R1: After reset, the register at 0xD4 reads 0x00, `osc_stop` is 0, and the rate is divide-by-16, giving exactly 4 enable pulses in any 64 consecutive cycles.
- R2: Only address 0xD4 is decoded. A read there returns the register. Any other address reads 0x00, and writes to other addresses change nothing.
- R3: Bits 6, 5, 2, 1 and 0 always read 0, and the values written to them are discarded. For example, writing 0xFF reads back as 0x98.
- R4: Bits 4:3 select the rate. Code 00 gives /16, 01 gives /8, 10 gives /2 and 11 gives undivided. Each pulse of `cpu_clk_en` lasts one cycle. A 4-bit counter counts from 0 after reset or wake-up. The pulse comes when the counter's low 4, 3, 1 or 0 bits are all ones.
- R5: A newly written rate code first applies in the cycle after the counter has stood at 15. Enables before that point follow the old rate.
- R6: When `stop_req` is sampled high, `osc_stop` rises in the next cycle. No `cpu_clk_en` pulse then occurs until Stop ends, and the counter holds its value.
- R7: While stopped with bit 7 = 0, a sampled `ext_irq` clears `osc_stop` in the next cycle. Counting then restarts from 0 at the stored rate. For /2 this means no enable in the first cycle after wake-up and an enable in the second.
- R8: While stopped with bit 7 = 1, `ext_irq` has no effect and `osc_stop` stays high.
- R9: Register writes issued while `osc_stop` is high are ignored.
- R10: A synchronous active-low reset ends Stop and restores the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| stop_req | input | 1 | Request to enter Stop mode |
| ext_irq | input | 1 | External interrupt, a wake-up candidate |
| cpu_clk_en | output | 1 | One-cycle CPU clock enable |
| osc_stop | output | 1 | High while the oscillator is halted (Stop state) |

## Verification
The hardest case to reach is a rate change that is still pending when Stop is entered. In that case, the wake-up must apply the stored code even though no counter wrap has occurred. A second hard case is a write arriving during Stop, which must be dropped.

The stimulus reaches these cases directly. It writes a new rate right after an enable pulse, when the counter is near 0, so the old rate stays visible for a window before the wrap. It then requests Stop, attempts a write, and releases with an interrupt. A behavioural model checks every cycle, and directed checks count pulses in aligned windows.

// File: rtl/clkctl_pkg.sv
// Shared constants and types for the clock control unit.
// Assumes an 8-bit register bus and a 4-bit prescaler.
package clkctl_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned PS_W     = 4;
    localparam int unsigned WAKE_BIT = 7;
    localparam int unsigned SEL_LO   = 3;
    localparam int unsigned N_RATES  = 4;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hD4;

    typedef enum logic [1:0] {
        RATE_DIV16 = 2'b00,
        RATE_DIV8  = 2'b01,
        RATE_DIV2  = 2'b10,
        RATE_DIV1  = 2'b11
    } rate_e;

    // Number of low counter bits that must all be ones for a pulse at rate r.
    function automatic int unsigned rate_tap_bits(input int unsigned r);
        case (r)
            0:       return PS_W;
            1:       return PS_W - 1;
            2:       return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/clkctl_regfile.sv
// Control register: address decode, write, readback.
// Holds the wake-disable field and the rate code. Other bits are not stored.
// Assumes a write takes effect on the clock edge at which bus_we is sampled.
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned DW       = DATA_W,
    parameter logic [AW-1:0] REG_ADDR = CTRL_ADDR,
    parameter int unsigned WB       = WAKE_BIT,
    parameter int unsigned SL       = SEL_LO
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          wr_block,
    output logic [DW-1:0] bus_rdata,
    output logic          wake_dis,
    output rate_e         div_sel
);
    localparam logic [DW-1:0] USED_MASK = DW'((1 << WB) | (3 << SL));

    logic addr_hit;
    logic unused_wdata;

    assign addr_hit     = (bus_addr == REG_ADDR);
    assign unused_wdata = ^(bus_wdata & ~USED_MASK);

    // Store the two functional fields on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_dis <= 1'b0;
            div_sel  <= RATE_DIV16;
        end else if (addr_hit && bus_we && !wr_block) begin
            wake_dis <= bus_wdata[WB];
            div_sel  <= rate_e'(bus_wdata[SL +: 2]);
        end
    end

    // Assemble read data; unused bits and other addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (addr_hit) begin
            bus_rdata[WB]      = wake_dis;
            bus_rdata[SL +: 2] = div_sel;
        end
    end
endmodule

// File: rtl/clkctl_prescaler.sv
// Free-running prescaler that produces the CPU clock enable.
// The active rate is reloaded from the register only at a counter wrap,
// or on restart, so enable spacing never mixes two rates in one period.
module clkctl_prescaler
    import clkctl_pkg::*;
#(
    parameter int unsigned CW = PS_W,
    parameter int unsigned NR = N_RATES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  rate_e         div_sel,
    output logic          clk_en,
    output logic [CW-1:0] count,
    output rate_e         act_sel
);
    logic [NR-1:0] tap_hit;
    logic          wrap;

    assign wrap = &count;

    // One tap comparator per rate: low K bits all ones.
    for (genvar r = 0; r < NR; r++) begin : g_tap
        localparam int unsigned K = rate_tap_bits(r);
        localparam logic [CW-1:0] MASK = CW'((64'd1 << K) - 64'd1);
        assign tap_hit[r] = &(count | ~MASK);
    end

    // Advance the counter and reload the active rate at wrap or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            act_sel <= RATE_DIV16;
        end else if (restart) begin
            count   <= '0;
            act_sel <= div_sel;
        end else if (run) begin
            count <= count + 1'b1;
            if (wrap) begin
                act_sel <= div_sel;
            end
        end
    end

    assign clk_en = run && tap_hit[act_sel];
endmodule

// File: rtl/clkctl_stop_ctrl.sv
// Stop-mode state: entered by stop_req, left by reset or by an external
// interrupt while wake-up is permitted (wake_dis low). Wake beats a
// simultaneous stop request.
module clkctl_stop_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic ext_irq,
    input  logic wake_dis,
    output logic stopped,
    output logic wake
);
    assign wake = stopped && ext_irq && !wake_dis;

    // Track the Stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped <= 1'b0;
        end else if (wake) begin
            stopped <= 1'b0;
        end else if (stop_req) begin
            stopped <= 1'b1;
        end
    end
endmodule

// File: rtl/clkctl_top.sv
// Clock control unit top: register, prescaler and Stop control.
// The clock input is the oscillator clock; the CPU uses cpu_clk_en.
module clkctl_top
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_req,
    input  logic              ext_irq,
    output logic              cpu_clk_en,
    output logic              osc_stop
);
    logic            wake_dis;
    rate_e           div_sel;
    rate_e           act_sel;
    logic            stopped;
    logic            wake;
    logic [PS_W-1:0] ps_count;

    clkctl_regfile u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .wr_block  (stopped),
        .bus_rdata (bus_rdata),
        .wake_dis  (wake_dis),
        .div_sel   (div_sel)
    );

    clkctl_stop_ctrl u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .ext_irq  (ext_irq),
        .wake_dis (wake_dis),
        .stopped  (stopped),
        .wake     (wake)
    );

    clkctl_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!stopped),
        .restart (wake),
        .div_sel (div_sel),
        .clk_en  (cpu_clk_en),
        .count   (ps_count),
        .act_sel (act_sel)
    );

    assign osc_stop = stopped;
endmodule

// File: rtl/clkctl_checker.sv
// Temporal checks on the clock control unit, bound into clkctl_top.
module clkctl_checker
    import clkctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ext_irq,
    input logic              cpu_clk_en,
    input logic              osc_stop,
    input logic              wake_dis,
    input logic [1:0]        div_sel,
    input logic [1:0]        act_sel,
    input logic [PS_W-1:0]   ps_count
);
    a_r2_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != CTRL_ADDR) |-> (bus_rdata == '0));

    a_r6_no_enable_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |-> !cpu_clk_en);

    a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !(ext_irq && !wake_dis)) |=> $stable(ps_count));

    a_r8_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && (wake_dis || !ext_irq)) |=> osc_stop);

    a_r7_wake_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !wake_dis && ext_irq) |=> (!osc_stop && ps_count == '0));

    a_r9_no_write_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |=> ($stable(div_sel) && $stable(wake_dis)));

    a_r5_rate_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_count != '1 && !osc_stop) |=> $stable(act_sel));
endmodule

bind clkctl_top clkctl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .ext_irq    (ext_irq),
    .cpu_clk_en (cpu_clk_en),
    .osc_stop   (osc_stop),
    .wake_dis   (wake_dis),
    .div_sel    (div_sel),
    .act_sel    (act_sel),
    .ps_count   (ps_count)
);

// File: tb/test_clkctl_top.sv
`timescale 1ns/1ps
module test_clkctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0;
    logic       ext_irq = 1'b0;
    logic       cpu_clk_en;
    logic       osc_stop;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state
    int m_cnt = 0, m_act = 0, m_sel = 0, m_wdis = 0, m_stop = 0;

    always #10 clk = ~clk;

    clkctl_top i_clkctl_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_req(stop_req),
        .ext_irq(ext_irq), .cpu_clk_en(cpu_clk_en), .osc_stop(osc_stop)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_en();
        if (m_stop != 0) return 0;
        case (m_act)
            0:       return (m_cnt == 15) ? 1 : 0;
            1:       return (m_cnt % 8 == 7) ? 1 : 0;
            2:       return (m_cnt % 2 == 1) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    // Behavioural model update on each oscillator edge.
    always @(posedge clk) begin
        int n_cnt, n_act, n_sel, n_wdis, n_stop;
        bit wk;
        n_cnt = m_cnt; n_act = m_act; n_sel = m_sel; n_wdis = m_wdis; n_stop = m_stop;
        if (!rst_n) begin
            n_cnt = 0; n_act = 0; n_sel = 0; n_wdis = 0; n_stop = 0;
        end else begin
            wk = (m_stop != 0) && ext_irq && (m_wdis == 0);
            if (wk) begin
                n_cnt = 0; n_act = m_sel; n_stop = 0;
            end else begin
                if (m_stop == 0) begin
                    if (m_cnt == 15) n_act = m_sel;
                    n_cnt = (m_cnt + 1) % 16;
                end
                if (stop_req) n_stop = 1;
            end
            if (bus_we && bus_addr == 8'hD4 && m_stop == 0) begin
                n_sel = int'(bus_wdata[4:3]);
                n_wdis = int'(bus_wdata[7]);
            end
        end
        m_cnt = n_cnt; m_act = n_act; m_sel = n_sel; m_wdis = n_wdis; m_stop = n_stop;
    end

    // Compare outputs against the model mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 cycle enable", int'(cpu_clk_en), model_en());
            check("R6 cycle osc_stop", int'(osc_stop), m_stop);
            check("R2 cycle rdata", int'(bus_rdata),
                  (bus_addr == 8'hD4) ? (m_wdis * 128 + m_sel * 8) : 0);
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        tick(); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick(); bus_we = 1'b0; bus_addr = 8'hD4;
    endtask

    task automatic count_en(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cpu_clk_en) n++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        int n;
        bus_addr = 8'hD4;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 reset readback", int'(bus_rdata), 0);
        check("R1 reset osc_stop", int'(osc_stop), 0);
        count_en(64, n);
        check("R1 reset rate /16 pulses", n, 4);

        // R4 each rate, measured after a settling period
        for (int s = 0; s < 4; s++) begin
            wr(8'hD4, 8'(s << 3));
            repeat (32) tick();
            count_en(64, n);
            check("R4 pulses per 64", n, (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 32 : 64);
        end

        // R2 foreign address: write ignored, reads zero
        wr(8'h55, 8'hFF);
        @(negedge clk);
        check("R2 reg unchanged", int'(bus_rdata), 8'h18);
        tick(); bus_addr = 8'h55;
        @(negedge clk);
        check("R2 other address reads zero", int'(bus_rdata), 0);
        tick(); bus_addr = 8'hD4;

        // R3 unused bits
        wr(8'hD4, 8'hFF);
        @(negedge clk);
        check("R3 write FF reads 98", int'(bus_rdata), 8'h98);
        wr(8'hD4, 8'h67);
        @(negedge clk);
        check("R3 write 67 reads 00", int'(bus_rdata), 8'h00);

        // R5 change is deferred to the wrap
        repeat (20) tick();
        @(negedge clk);
        while (!cpu_clk_en) @(negedge clk);
        wr(8'hD4, 8'h18);
        count_en(10, n);
        check("R5 old rate before wrap", n, 0);
        count_en(24, n);
        check("R5 new rate after wrap", n, 24 - 4);

        // R8 wake disabled: interrupt ignored
        wr(8'hD4, 8'h90);
        tick(); stop_req = 1'b1;
        tick(); stop_req = 1'b0;
        @(negedge clk);
        check("R6 stop entered", int'(osc_stop), 1);
        tick(); ext_irq = 1'b1;
        tick(); ext_irq = 1'b0;
        count_en(20, n);
        check("R6 no enable while stopped", n, 0);
        check("R8 still stopped", int'(osc_stop), 1);

        // R10 reset releases Stop
        tick(); rst_n = 1'b0;
        tick(); rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset clears stop", int'(osc_stop), 0);
        check("R10 reset readback", int'(bus_rdata), 0);

        // R7 and R9: pending change through Stop, write dropped, wake at /2
        repeat (5) tick();
        wr(8'hD4, 8'h10);
        tick(); stop_req = 1'b1;
        tick(); stop_req = 1'b0;
        wr(8'hD4, 8'h98);
        @(negedge clk);
        check("R9 write while stopped ignored", int'(bus_rdata), 8'h10);
        tick(); ext_irq = 1'b1;
        tick(); ext_irq = 1'b0;
        @(negedge clk);
        check("R7 awake", int'(osc_stop), 0);
        check("R7 first cycle no enable", int'(cpu_clk_en), 0);
        @(negedge clk);
        check("R7 second cycle enable", int'(cpu_clk_en), 1);
        count_en(32, n);
        check("R7 /2 after wake", n, 16);

        repeat (4) tick();
        finish_run();
    end
endmodule